// File: doc/BRIEF.md
# Sequential Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles, one quotient bit per cycle. A pulse on the start input captures the dividend, the divisor and a mode bit that selects two's-complement or unsigned interpretation. The block then runs its iterations, raises a one-cycle completion pulse, and presents the remainder on the high result port and the quotient on the low result port. Both result ports hold those values until the next division completes.

A single double-width shift register carries the partial remainder in its upper half and the quotient as it is built in its lower half. Each iteration is a restoring shift-and-subtract step. In two's-complement mode the block divides the operand magnitudes. It then negates the quotient when the operand signs differ, and gives the remainder the sign of the dividend. A zero divisor is not trapped. The block finishes normally and returns whatever the iterations produce.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode (mode bit 0), the low result is floor(dividend / divisor) and the high result is dividend mod divisor, for any nonzero divisor.
- R2: In signed mode (mode bit 1), the low result has magnitude |dividend| / |divisor|, rounded toward zero. It is negated when exactly one operand has bit 31 set.
- R3: In signed mode, the high result has magnitude |dividend| mod |divisor| and carries the dividend's sign, so that dividend = quotient × divisor + remainder.
- R4: The busy output is high from the clock edge that accepts start and stays high for exactly 32 cycles. It is then low again.
- R5: The done output pulses high for one cycle, in the first cycle in which busy is low again after a division, and the high and low results are valid in that cycle.
- R6: A start pulse that arrives while busy is high is ignored. The running division completes with its original operands and its original timing, and no new division begins.
- R7: With a zero divisor, the quotient magnitude is all ones and the remainder magnitude equals the dividend magnitude, before the sign rules of R2 and R3 are applied. No flag is raised.
- R8: The high and low results change only in the cycle in which done is high. The operand inputs may change freely after the start cycle.
- R9: After reset, busy and done are low and both results are zero.
- R10: Signed division of 0x80000000 by 0xFFFFFFFF yields a low result of 0x80000000 and a high result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division; sampled only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, captured with start |
| divisor_i | input | 32 | Divisor, captured with start |
| busy_o | output | 1 | High while iterations run |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Remainder of the last completed division |
| lo_o | output | 32 | Quotient of the last completed division |

## Verification
The hardest states to reach from the ports are a second start that arrives in the middle of a running division and the operand extremes at which magnitude conversion or sign correction could wrap. To reach the first, the stimulus raises start at chosen iteration counts between the first and the last iteration. It also scrambles the operand inputs right after capture, then checks that the result and the latency still belong to the first request. To reach the second, directed cases cover the most negative dividend over minus one, the all-ones unsigned operands and zero divisors in both modes. Random operands follow, with divisors masked to assorted widths so that the quotients span many sizes.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/div_magnitude.sv
module div_magnitude #(
    parameter int W = 32
) (
    input  logic [W-1:0] value_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    always_comb begin
        neg_o = signed_i & value_i[W-1];
        mag_o = neg_o ? (~value_i + {{(W-1){1'b0}}, 1'b1}) : value_i;
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   dvs_i,
    output logic [2*W-1:0] acc_o
);
    logic [2*W-1:0] shifted;
    logic [W:0]     trial;

    always_comb begin
        shifted = {acc_i[2*W-2:0], 1'b0};
        // remainder after shift may need W+1 bits
        trial   = {acc_i[2*W-1], acc_i[2*W-2:W-1]} - {1'b0, dvs_i};
        if (trial[W]) begin
            acc_o = shifted;
        end else begin
            acc_o = {trial[W-1:0], shifted[W-1:1], 1'b1};
        end
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] q_mag_i,
    input  logic [W-1:0] r_mag_i,
    input  logic         neg_q_i,
    input  logic         neg_r_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] r_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        q_o = neg_q_i ? (~q_mag_i + ONE) : q_mag_i;
        r_o = neg_r_i ? (~r_mag_i + ONE) : r_mag_i;
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        div_state_e     state;
        logic [2*W-1:0] acc;
        logic [W-1:0]   dvs;
        logic           neg_q;
        logic           neg_r;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
        logic           done;
    } div_regs_t;

    div_regs_t r_q, r_d;

    logic [W-1:0]   dd_mag, dv_mag;
    logic           dd_neg, dv_neg;
    logic [2*W-1:0] acc_step;
    logic [W-1:0]   q_fix, r_fix;

    div_magnitude #(.W(W)) u_mag_dd (
        .value_i (dividend_i),
        .signed_i(signed_i),
        .mag_o   (dd_mag),
        .neg_o   (dd_neg)
    );

    div_magnitude #(.W(W)) u_mag_dv (
        .value_i (divisor_i),
        .signed_i(signed_i),
        .mag_o   (dv_mag),
        .neg_o   (dv_neg)
    );

    div_step #(.W(W)) u_step (
        .acc_i(r_q.acc),
        .dvs_i(r_q.dvs),
        .acc_o(acc_step)
    );

    div_sign_fix #(.W(W)) u_fix (
        .q_mag_i(acc_step[W-1:0]),
        .r_mag_i(acc_step[2*W-1:W]),
        .neg_q_i(r_q.neg_q),
        .neg_r_i(r_q.neg_r),
        .q_o    (q_fix),
        .r_o    (r_fix)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_RUN;
                    r_d.acc   = {{W{1'b0}}, dd_mag};
                    r_d.dvs   = dv_mag;
                    r_d.neg_q = dd_neg ^ dv_neg;
                    r_d.neg_r = dd_neg;
                    r_d.cnt   = '0;
                end
            end
            ST_RUN: begin
                r_d.acc = acc_step;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.hi    = r_fix;
                    r_d.lo    = q_fix;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, acc: '0, dvs: '0, neg_q: 1'b0,
                     neg_r: 1'b0, cnt: '0, hi: '0, lo: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state == ST_RUN);
    assign done_o = r_q.done;
    assign hi_o   = r_q.hi;
    assign lo_o   = r_q.lo;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    localparam int NW = $clog2(W) + 2;

    logic [NW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_cnt <= '0;
        else if (!busy_o) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_busy_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == NW'(W)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && busy_cnt < NW'(W - 1)) |=> busy_o);

    p_results_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

endmodule

bind seq_divider div_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/seq_divider_tb.sv
`timescale 1ns/1ps
module seq_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o;
    logic [31:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    seq_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected results from the requirement rules
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                         output logic [31:0] q, output logic [31:0] r);
        logic an, bn;
        logic [31:0] am, bm;
        an = sgn && a[31];
        bn = sgn && b[31];
        am = an ? -a : a;
        bm = bn ? -b : b;
        if (bm == 0) begin      // R7
            q = 32'hFFFF_FFFF;
            r = am;
        end else begin
            q = am / bm;
            r = am % bm;
        end
        if (an ^ bn) q = -q;    // R2
        if (an) r = -r;         // R3
    endtask

    task automatic run_div(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                           input int intr_at, input string qtag, input string rtag);
        logic [31:0] eq, er, prev_hi, prev_lo;
        int cyc;
        model(a, b, sgn, eq, er);
        @(negedge clk);
        prev_hi = hi_o;
        prev_lo = lo_o;
        start_i = 1'b1; dividend_i = a; divisor_i = b; signed_i = sgn;
        @(negedge clk);
        start_i = 1'b0;
        dividend_i = $urandom; divisor_i = $urandom; signed_i = ~sgn;
        chk(busy_o === 1'b1, "R4 busy after start", {31'b0, busy_o}, 32'd1);
        cyc = 1;
        while (!done_o && cyc < 100) begin
            start_i = (cyc == intr_at);
            if (cyc == 16) begin
                chk(hi_o === prev_hi && lo_o === prev_lo, "R8 results held", hi_o, prev_hi);
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(cyc == 33, "R4 latency", cyc, 33);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R5 done with busy low", {30'b0, done_o, busy_o}, 32'd2);
        chk(lo_o === eq, qtag, lo_o, eq);
        chk(hi_o === er, rtag, hi_o, er);
        @(negedge clk);
        chk(done_o === 1'b0, "R5 single pulse", {31'b0, done_o}, 32'd0);
        if (intr_at > 0) begin
            chk(busy_o === 1'b0, "R6 no restart", {31'b0, busy_o}, 32'd0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        logic rs;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        start_i = 1'b1;  // held during reset, must be ignored
        @(negedge clk);
        // R9 reset state
        chk(busy_o === 1'b0, "R9 busy", {31'b0, busy_o}, 0);
        chk(done_o === 1'b0, "R9 done", {31'b0, done_o}, 0);
        chk(hi_o === 32'd0, "R9 hi", hi_o, 0);
        chk(lo_o === 32'd0, "R9 lo", lo_o, 0);
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        run_div(32'd100, 32'd7, 1'b0, 0, "R1 q", "R1 r");
        run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 0, "R1 q", "R1 r");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R1 q", "R1 r");
        run_div(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 0, "R1 q", "R1 r");
        run_div(-32'sd7, 32'd3, 1'b1, 0, "R2 q", "R3 r");
        run_div(32'd7, -32'sd3, 1'b1, 0, "R2 q", "R3 r");
        run_div(-32'sd7, -32'sd3, 1'b1, 0, "R2 q", "R3 r");
        run_div(-32'sd6, 32'd3, 1'b1, 0, "R2 q", "R3 r");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, "R10 q", "R10 r");
        run_div(32'h8000_0000, 32'd1, 1'b1, 0, "R2 q", "R3 r");
        run_div(32'h1234_5678, 32'd0, 1'b0, 0, "R7 q", "R7 r");
        run_div(-32'sd1000, 32'd0, 1'b1, 0, "R7 q", "R7 r");
        run_div(32'd1000, 32'd0, 1'b1, 0, "R7 q", "R7 r");
        run_div(32'd123456, 32'd789, 1'b0, 1, "R6 q", "R6 r");
        run_div(-32'sd99999, 32'd17, 1'b1, 20, "R6 q", "R6 r");
        run_div(32'hDEAD_BEEF, 32'd3, 1'b0, 32, "R6 q", "R6 r");

        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            rb = $urandom;
            case ($urandom % 4)
                0: rb = rb & 32'h0000_00FF;
                1: rb = rb & 32'h0000_FFFF;
                2: rb = rb | 32'h8000_0000;
                default: ;
            endcase
            if (rb == 0) rb = 32'd5;
            rs = 1'(($urandom % 2));
            if (($urandom % 8) == 0) begin
                run_div(ra, rb, rs, 1 + int'($urandom % 32), "R6 q", "R6 r");
            end else if (rs) begin
                run_div(ra, rb, rs, 0, "R2 q", "R3 r");
            end else begin
                run_div(ra, rb, rs, 0, "R1 q", "R1 r");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule